// File: doc/BRIEF.md
# Wraparound Variable-Length Instruction Extractor

This block takes instructions out of a circular byte buffer that another unit fills and hands them, one at a time, to a bounded instruction queue. An instruction is either one dword (4 bytes) or two dwords (8 bytes). Its length comes from an external length decoder. The block shows the decoder the first dword of each instruction and reads back a single flag. The block keeps its own byte-granular read pointer and a count of fetched bytes that have not yet been consumed. Whoever fills the buffer adds to that count with a credit strobe. A branch or a flush reloads the pointer through a restart strobe.

The buffer is read through a combinational read port, one dword per cycle. A long instruction whose first dword sits in the last dword slot of the buffer is split across the physical end of the buffer. The block reads that first dword, wraps the pointer to the start, and takes the second dword from buffer byte 0. A one-dword instruction needs one cycle and a two-dword instruction needs two. The queue side is a valid/ready stream. The output word stays frozen while `iq_valid` is high and `iq_ready` is low, and no new extraction starts until the held word has been taken.

Top module: `wrap_insn_extractor`

## Requirements
- R1: After reset, `iq_valid` is 0, `rd_ptr` is 0 and `bytes_left` is 0.
- R2: A new instruction is started only when `bytes_left` is at least 8 and the output slot is free (`iq_valid` low, or `iq_ready` high). Otherwise `rd_ptr` and `bytes_left` hold, so a tail of fewer than 8 bytes is left unconsumed.
- R3: When the length flag `len_is_long` is 0 for the first dword, the block pushes `iq_word = {32'h0, dword}` with `iq_len8 = 0`. `rd_ptr` advances by 4 and `bytes_left` drops by 4.
- R4: When `len_is_long` is 1 for the first dword, the block reads the next dword in the following cycle and pushes `iq_word = {second, first}` with `iq_len8 = 1`, so the first dword is the low half. `rd_ptr` advances by 8, and `len_is_long` is ignored while the second dword is read.
- R5: A long instruction whose first dword is at byte `BUF_BYTES-4` is split. Its second dword comes from byte 0, and `rd_ptr` ends at 4.
- R6: `rd_ptr` is a byte address that stays below `BUF_BYTES`. Advancing from `BUF_BYTES-4` gives 0.
- R7: While `iq_valid` is high and `iq_ready` is low, `iq_word` and `iq_len8` are stable and no further dword is read.
- R8: A cycle with `credit_valid` high adds `credit_bytes` to `bytes_left`, in the same cycle as any consumption. The credit giver must keep the sum at or below `BUF_BYTES`.
- R9: A `restart` cycle loads `rd_ptr` from `restart_ptr`, which must be dword-aligned and below `BUF_BYTES`. It also clears `bytes_left`, drops any held output, and abandons a half-read long instruction. A credit given in the same cycle is discarded.
- R10: At most one instruction is pushed per cycle. With `iq_ready` held high, consecutive one-dword instructions are pushed on consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| restart | input | 1 | Reload pointer, clear byte count, drop pending work |
| restart_ptr | input | $clog2(BUF_BYTES) | Byte address loaded on restart (dword-aligned) |
| credit_valid | input | 1 | Adds `credit_bytes` to the unconsumed count |
| credit_bytes | input | $clog2(BUF_BYTES+1) | Number of newly fetched bytes |
| rd_ptr | output | $clog2(BUF_BYTES) | Byte read pointer |
| bytes_left | output | $clog2(BUF_BYTES+1) | Fetched bytes not yet consumed |
| mem_addr | output | $clog2(BUF_BYTES)-2 | Dword index into buffer storage |
| mem_data | input | 32 | Dword read combinationally at `mem_addr` |
| len_dword | output | 32 | Dword presented to the length decoder |
| len_is_long | input | 1 | Decoder flag: 1 means 8-byte instruction |
| iq_valid | output | 1 | Instruction available to the queue |
| iq_ready | input | 1 | Queue can accept this cycle |
| iq_word | output | 64 | Instruction word, first dword in bits 31:0 |
| iq_len8 | output | 1 | 1 for an 8-byte instruction, 0 for 4 bytes |

## Verification
Directed runs use short instructions at the buffer tail to exercise pointer wrap without splitting. A long instruction in the last slot separates a correct split from one that reads past the end. A non-split long instruction whose second dword carries a set flag shows that the flag is sampled only on the first dword. A credit that leaves 4 or 12 bytes shows that the 8-byte threshold leaves a tail behind. A held output under back-pressure, followed by a restart, separates stalling from silently dropping or advancing. The constrained-random phase mixes random lengths, random credits and random queue readiness over the whole buffer. It is compared push by push against a bench model of the pointer and byte count, which catches ordering and counting errors that only show up when wraps and stalls coincide.

// File: rtl/wx_pkg.sv
package wx_pkg;
  typedef enum logic {
    WX_LO = 1'b0,
    WX_HI = 1'b1
  } wx_phase_e;

  localparam int unsigned WX_DW_BYTES  = 4;
  localparam int unsigned WX_WIN_BYTES = 8;
endpackage

// File: rtl/wx_ptr_track.sv
module wx_ptr_track #(
  parameter int unsigned BUF_BYTES = 64,
  parameter int unsigned PW = $clog2(BUF_BYTES),
  parameter int unsigned CW = $clog2(BUF_BYTES + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          restart,
  input  logic [PW-1:0] restart_ptr,
  input  logic          credit_valid,
  input  logic [CW-1:0] credit_bytes,
  input  logic          adv,
  output logic [PW-1:0] ptr,
  output logic [CW-1:0] bytes_left,
  output logic          at_tail
);
  import wx_pkg::*;

  localparam logic [PW:0]   END_W   = (PW+1)'(BUF_BYTES);
  localparam logic [PW-1:0] TAIL_P  = PW'(BUF_BYTES - WX_DW_BYTES);
  localparam bit            POW2BUF = ((BUF_BYTES & (BUF_BYTES - 1)) == 0);

  logic [PW-1:0] ptr_q, ptr_wrap;
  logic [PW:0]   ptr_sum;
  logic [CW-1:0] bytes_q, add_v, sub_v;

  assign ptr_sum = {1'b0, ptr_q} + (PW+1)'(WX_DW_BYTES);

  generate
    if (POW2BUF) begin : g_wrap_pow2
      assign ptr_wrap = ptr_sum[PW-1:0];
    end else begin : g_wrap_cmp
      assign ptr_wrap = (ptr_sum >= END_W) ? '0 : ptr_sum[PW-1:0];
    end
  endgenerate

  assign add_v = credit_valid ? credit_bytes : '0;
  assign sub_v = adv ? CW'(WX_DW_BYTES) : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ptr_q   <= '0;
      bytes_q <= '0;
    end else if (restart) begin
      ptr_q   <= restart_ptr;
      bytes_q <= '0;
    end else begin
      if (adv) ptr_q <= ptr_wrap;
      bytes_q <= bytes_q + add_v - sub_v;
    end
  end

  assign ptr        = ptr_q;
  assign bytes_left = bytes_q;
  assign at_tail    = (ptr_q == TAIL_P);

  // R6
  ptr_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ({1'b0, ptr_q} < END_W));

  // R6
  tail_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && at_tail && !restart) |=> (ptr_q == '0));

  // R8
  credit_add_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (credit_valid && !adv && !restart) |=> (bytes_q == $past(bytes_q) + $past(credit_bytes)));

  // R9
  restart_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (ptr_q == $past(restart_ptr) && bytes_q == '0));
endmodule

// File: rtl/wx_seq.sv
module wx_seq #(
  parameter int unsigned CW = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              restart,
  input  logic [CW-1:0]     bytes_left,
  input  logic              slot_free,
  input  logic [31:0]       mem_data,
  input  logic              len_is_long,
  input  logic              at_tail,
  output logic              adv,
  output logic              load,
  output logic [63:0]       word,
  output logic              len8,
  output wx_pkg::wx_phase_e phase,
  output logic              split
);
  import wx_pkg::*;

  wx_phase_e   phase_q;
  logic [31:0] lo_q;
  logic        split_q;
  logic        enough, go_lo, in_hi;

  assign enough = (bytes_left >= CW'(WX_WIN_BYTES));
  assign go_lo  = (phase_q == WX_LO) && enough && slot_free && !restart;
  assign in_hi  = (phase_q == WX_HI) && !restart;

  assign adv  = go_lo || in_hi;
  assign load = (go_lo && !len_is_long) || in_hi;
  assign word = in_hi ? {mem_data, lo_q} : {32'h0, mem_data};
  assign len8 = in_hi;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase_q <= WX_LO;
      lo_q    <= '0;
      split_q <= 1'b0;
    end else if (restart) begin
      phase_q <= WX_LO;
      split_q <= 1'b0;
    end else if (go_lo) begin
      lo_q    <= mem_data;
      split_q <= at_tail;
      if (len_is_long) phase_q <= WX_HI;
    end else if (in_hi) begin
      phase_q <= WX_LO;
      split_q <= 1'b0;
    end
  end

  assign phase = phase_q;
  assign split = split_q;

  // R4
  hi_funds_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == WX_HI) |-> (bytes_left >= CW'(WX_DW_BYTES)));

  // R4
  hi_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == WX_HI) |=> (phase_q == WX_LO));

  // R7
  hi_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == WX_HI) |-> slot_free);
endmodule

// File: rtl/wx_out_reg.sv
module wx_out_reg (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        restart,
  input  logic        load,
  input  logic [63:0] word_in,
  input  logic        len8_in,
  input  logic        ready,
  output logic        valid,
  output logic [63:0] word,
  output logic        len8,
  output logic        slot_free
);
  logic        vld_q;
  logic [63:0] word_q;
  logic        len8_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld_q  <= 1'b0;
      word_q <= '0;
      len8_q <= 1'b0;
    end else if (restart) begin
      vld_q <= 1'b0;
    end else if (load) begin
      vld_q  <= 1'b1;
      word_q <= word_in;
      len8_q <= len8_in;
    end else if (ready) begin
      vld_q <= 1'b0;
    end
  end

  assign valid     = vld_q;
  assign word      = word_q;
  assign len8      = len8_q;
  assign slot_free = !vld_q || ready;

  // R7
  hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (vld_q && !ready && !restart) |=> (vld_q && $stable(word_q) && $stable(len8_q)));

  // R9
  restart_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> !vld_q);
endmodule

// File: rtl/wrap_insn_extractor.sv
module wrap_insn_extractor #(
  parameter int unsigned BUF_BYTES = 64,
  localparam int unsigned PW = $clog2(BUF_BYTES),
  localparam int unsigned CW = $clog2(BUF_BYTES + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          restart,
  input  logic [PW-1:0] restart_ptr,
  input  logic          credit_valid,
  input  logic [CW-1:0] credit_bytes,
  output logic [PW-1:0] rd_ptr,
  output logic [CW-1:0] bytes_left,
  output logic [PW-3:0] mem_addr,
  input  logic [31:0]   mem_data,
  output logic [31:0]   len_dword,
  input  logic          len_is_long,
  output logic          iq_valid,
  input  logic          iq_ready,
  output logic [63:0]   iq_word,
  output logic          iq_len8
);
  import wx_pkg::*;

  logic        adv, load, at_tail, slot_free, split;
  logic [63:0] seq_word;
  logic        seq_len8;
  wx_phase_e   phase;

  wx_ptr_track #(.BUF_BYTES(BUF_BYTES), .PW(PW), .CW(CW)) u_ptr (
    .clk          (clk),
    .rst_n        (rst_n),
    .restart      (restart),
    .restart_ptr  (restart_ptr),
    .credit_valid (credit_valid),
    .credit_bytes (credit_bytes),
    .adv          (adv),
    .ptr          (rd_ptr),
    .bytes_left   (bytes_left),
    .at_tail      (at_tail)
  );

  wx_seq #(.CW(CW)) u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .restart     (restart),
    .bytes_left  (bytes_left),
    .slot_free   (slot_free),
    .mem_data    (mem_data),
    .len_is_long (len_is_long),
    .at_tail     (at_tail),
    .adv         (adv),
    .load        (load),
    .word        (seq_word),
    .len8        (seq_len8),
    .phase       (phase),
    .split       (split)
  );

  wx_out_reg u_out (
    .clk       (clk),
    .rst_n     (rst_n),
    .restart   (restart),
    .load      (load),
    .word_in   (seq_word),
    .len8_in   (seq_len8),
    .ready     (iq_ready),
    .valid     (iq_valid),
    .word      (iq_word),
    .len8      (iq_len8),
    .slot_free (slot_free)
  );

  assign mem_addr  = rd_ptr[PW-1:2];
  assign len_dword = mem_data;

  // R2
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == WX_LO && bytes_left < CW'(WX_WIN_BYTES) && !restart) |=> $stable(rd_ptr));

  // R5
  split_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == WX_HI && split) |-> (rd_ptr == '0));

  // R10
  push_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (iq_valid && iq_ready && !restart && phase == WX_LO) |=> (!iq_valid || $changed(rd_ptr) || $past(phase) == WX_HI));
endmodule

// File: tb/test_wrap_insn_extractor.sv
module test_wrap_insn_extractor;
  localparam int BB = 64;
  localparam int PW = 6;
  localparam int CW = 7;
  localparam int ND = BB / 4;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic          rst_n = 1'b0;
  logic          restart = 1'b0;
  logic [PW-1:0] restart_ptr = '0;
  logic          credit_valid = 1'b0;
  logic [CW-1:0] credit_bytes = '0;
  logic [PW-1:0] rd_ptr;
  logic [CW-1:0] bytes_left;
  logic [PW-3:0] mem_addr;
  logic [31:0]   mem_data, len_dword;
  logic          len_is_long;
  logic          iq_valid;
  logic          iq_ready = 1'b0;
  logic [63:0]   iq_word;
  logic          iq_len8;

  logic [31:0] mem [ND];

  assign mem_data    = mem[mem_addr];
  assign len_is_long = len_dword[31];

  wrap_insn_extractor #(.BUF_BYTES(BB)) i_wrap_insn_extractor (
    .clk(clk), .rst_n(rst_n), .restart(restart), .restart_ptr(restart_ptr),
    .credit_valid(credit_valid), .credit_bytes(credit_bytes),
    .rd_ptr(rd_ptr), .bytes_left(bytes_left), .mem_addr(mem_addr),
    .mem_data(mem_data), .len_dword(len_dword), .len_is_long(len_is_long),
    .iq_valid(iq_valid), .iq_ready(iq_ready), .iq_word(iq_word), .iq_len8(iq_len8)
  );

  int n_chk = 0;
  int n_fail = 0;
  int n_push = 0;
  logic [PW-1:0] m_ptr = '0;
  int m_bytes = 0;

  function automatic logic [63:0] exp_word(logic [PW-1:0] p);
    logic [31:0]   first, second;
    logic [PW-1:0] p2;
    first = mem[p[PW-1:2]];
    p2 = p + PW'(4);
    second = mem[p2[PW-1:2]];
    return first[31] ? {second, first} : {32'h0, first};
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      if (restart) begin
        m_ptr = restart_ptr;
        m_bytes = 0;
      end else begin
        if (credit_valid) m_bytes += int'(credit_bytes);
        if (iq_valid && iq_ready) begin
          logic [63:0] ew;
          bit lng;
          string tg;
          ew = exp_word(m_ptr);
          lng = ew[31];
          if (lng && m_ptr == PW'(BB - 4)) tg = "R5";
          else if (lng) tg = "R4";
          else if (m_ptr == PW'(BB - 4)) tg = "R6";
          else tg = "R3";
          chk(iq_word == ew, tg, iq_word, ew);
          chk(iq_len8 == lng, tg, 64'(iq_len8), 64'(lng));
          m_ptr = m_ptr + PW'(lng ? 8 : 4);
          m_bytes -= lng ? 8 : 4;
          n_push++;
        end
      end
    end
  end

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic do_restart(input int p);
    restart = 1'b1;
    restart_ptr = PW'(p);
    tick();
    restart = 1'b0;
  endtask

  task automatic do_credit(input int c);
    credit_valid = 1'b1;
    credit_bytes = CW'(c);
    tick();
    credit_valid = 1'b0;
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    int p0;
    logic [63:0] held;
    int vcount, run, maxrun;
    for (int i = 0; i < ND; i++) mem[i] = 32'h0000_1000 + 32'(i);

    // R1 reset state
    repeat (3) tick();
    @(negedge clk);
    chk(iq_valid == 1'b0, "R1", 64'(iq_valid), 64'd0);
    chk(rd_ptr == '0, "R1", 64'(rd_ptr), 64'd0);
    chk(bytes_left == '0, "R1", 64'(bytes_left), 64'd0);
    tick();
    rst_n = 1'b1;
    iq_ready = 1'b1;
    tick();

    // R2: 4 bytes are not enough to start
    do_restart(0);
    do_credit(4);
    repeat (4) tick();
    @(negedge clk);
    chk(iq_valid == 1'b0, "R2", 64'(iq_valid), 64'd0);
    chk(rd_ptr == '0, "R2", 64'(rd_ptr), 64'd0);
    chk(bytes_left == CW'(4), "R8", 64'(bytes_left), 64'd4);
    tick();
    p0 = n_push;
    do_credit(4);
    repeat (5) tick();
    @(negedge clk);
    chk(rd_ptr == PW'(4), "R2", 64'(rd_ptr), 64'd4);
    chk(bytes_left == CW'(4), "R2", 64'(bytes_left), 64'd4);
    chk(n_push == p0 + 1, "R3", 64'(n_push - p0), 64'd1);
    tick();

    // R3/R6: two shorts at the tail, pointer wraps to 0
    mem[14] = 32'h0abc_0014;
    mem[15] = 32'h0abc_0015;
    do_restart(56);
    do_credit(12);
    repeat (6) tick();
    @(negedge clk);
    chk(rd_ptr == '0, "R6", 64'(rd_ptr), 64'd0);
    chk(bytes_left == CW'(4), "R2", 64'(bytes_left), 64'd4);
    tick();

    // R4: non-split long, second dword flag ignored
    mem[4] = 32'h8000_0a04;
    mem[5] = 32'h8000_0a05;
    p0 = n_push;
    do_restart(16);
    do_credit(8);
    repeat (5) tick();
    @(negedge clk);
    chk(rd_ptr == PW'(24), "R4", 64'(rd_ptr), 64'd24);
    chk(n_push == p0 + 1, "R4", 64'(n_push - p0), 64'd1);
    tick();

    // R5: split long at the last slot
    mem[15] = 32'h8000_5f15;
    mem[0]  = 32'h0000_5f00;
    p0 = n_push;
    do_restart(60);
    do_credit(8);
    repeat (5) tick();
    @(negedge clk);
    chk(rd_ptr == PW'(4), "R5", 64'(rd_ptr), 64'd4);
    chk(bytes_left == '0, "R5", 64'(bytes_left), 64'd0);
    chk(n_push == p0 + 1, "R5", 64'(n_push - p0), 64'd1);
    tick();

    // R7: back-pressure holds the word and stops reading
    mem[0] = 32'h0000_7700;
    mem[1] = 32'h0000_7701;
    iq_ready = 1'b0;
    do_restart(0);
    do_credit(16);
    repeat (3) tick();
    @(negedge clk);
    held = iq_word;
    chk(iq_valid == 1'b1, "R7", 64'(iq_valid), 64'd1);
    chk(iq_word == {32'h0, mem[0]}, "R7", iq_word, {32'h0, mem[0]});
    repeat (4) tick();
    @(negedge clk);
    chk(iq_word == held && iq_valid, "R7", iq_word, held);
    chk(rd_ptr == PW'(4), "R7", 64'(rd_ptr), 64'd4);
    tick();

    // R9: restart drops the held word
    do_restart(8);
    @(negedge clk);
    chk(iq_valid == 1'b0, "R9", 64'(iq_valid), 64'd0);
    chk(rd_ptr == PW'(8), "R9", 64'(rd_ptr), 64'd8);
    chk(bytes_left == '0, "R9", 64'(bytes_left), 64'd0);
    tick();

    // R10: consecutive shorts push back to back
    for (int i = 0; i < 4; i++) mem[i] = 32'h0000_a000 + 32'(i);
    iq_ready = 1'b1;
    do_restart(0);
    credit_valid = 1'b1;
    credit_bytes = CW'(16);
    vcount = 0; run = 0; maxrun = 0;
    for (int i = 0; i < 8; i++) begin
      tick();
      credit_valid = 1'b0;
      @(negedge clk);
      if (iq_valid) begin vcount++; run++; end else run = 0;
      if (run > maxrun) maxrun = run;
    end
    chk(vcount == 3, "R10", 64'(vcount), 64'd3);
    chk(maxrun == 3, "R10", 64'(maxrun), 64'd3);
    tick();

    // Constrained random phase
    void'($urandom(32'd2024));
    for (int i = 0; i < ND; i++) mem[i] = $urandom;
    do_restart(4 * ($urandom % ND));
    p0 = n_push;
    for (int cyc = 0; cyc < 4000; cyc++) begin
      int c;
      iq_ready = ($urandom % 4) != 0;
      c = ($urandom % 2) ? 4 : 8;
      if (($urandom % 3) == 0 && m_bytes + c <= BB) begin
        credit_valid = 1'b1;
        credit_bytes = CW'(c);
      end else begin
        credit_valid = 1'b0;
      end
      tick();
    end
    credit_valid = 1'b0;
    iq_ready = 1'b1;
    repeat (20) tick();
    @(negedge clk);
    chk(bytes_left == CW'(m_bytes), "R8", 64'(bytes_left), 64'(m_bytes));
    chk(rd_ptr == m_ptr, "R6", 64'(rd_ptr), 64'(m_ptr));
    chk(m_bytes < 8, "R2", 64'(m_bytes), 64'd7);
    chk(n_push - p0 > 200, "R10", 64'(n_push - p0), 64'd201);
    finish_run();
  end
endmodule